// File: doc/BRIEF.md
# Pipeline Hazard Stall and Squash Controller

This block sits beside the decode stage of a five-stage in-order pipeline. Every cycle it decides whether fetch and decode may advance, whether a no-op must go into the decode/execute register, whether the instruction just fetched must be discarded, and whether the program counter should take the branch target. It is purely combinational from its data inputs to its control outputs. The clock and reset are used only by the embedded checks.

Three kinds of stall are merged here. The first is a load-to-use dependence. When the instruction in execute is a load whose destination is a register that the decode instruction reads, the controller holds decode for one slot and inserts a bubble; the forwarding network then supplies the loaded value. The second is the branch. Branches are compared and their targets formed in decode, and a parameter selects how the slot after a branch is handled. The third is an optional guard for a single memory shared by fetch and data access, selected by a second parameter.

The three branch policies are:
- a one-slot stall on every branch;
- predict-not-taken, with a squash when the branch is taken;
- a delay slot that always runs.

Top module: `hazard_unit`

## Requirements
- R1: When the execute stage holds a load (`ex_is_load_i`=1) whose destination equals a source that the decode instruction actually uses, the outputs are `pc_we_o`=0, `ifid_we_o`=0 and `bubble_o`=1 in that cycle. A dependent instruction right after a load therefore costs exactly one extra cycle.
- R2: A destination of register 0, a match on a source flagged as unused, or a match with a non-load in execute never causes a stall.
- R3: A load followed by an independent instruction runs with no extra cycle. A program of N instructions with no hazards completes in N+4 cycles.
- R4: A branch in decode that is taken and not stalled drives `pc_sel_branch_o`=1. It drives 0 when the branch is not taken.
- R5: In predict-not-taken mode (the default), `ifid_flush_o`=1 only for a taken, unstalled branch. A taken branch costs one cycle and a not-taken branch costs none.
- R6: In branch-stall mode, every unstalled branch in decode drives `ifid_flush_o`=1, whatever its outcome.
- R7: In delay-slot mode, `ifid_flush_o` stays 0 for taken and not-taken branches, so the delay-slot instruction proceeds.
- R8: A stall from any source takes priority over a branch decision in the same cycle: `pc_sel_branch_o`=0 and `ifid_flush_o`=0. The branch is decided again on a later cycle. A taken branch that depends on a load costs two extra cycles in total.
- R9: With the shared-memory option on, `mem_access_i`=1 causes the same hold-and-bubble output as R1. With the option off, `mem_access_i` has no effect.
- R10: With no hazard and no branch, the outputs are `pc_we_o`=1, `ifid_we_o`=1, `bubble_o`=0, `ifid_flush_o`=0 and `pc_sel_branch_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, used by the embedded checks |
| rst_ni | input | 1 | Active-low asynchronous reset, disables the checks |
| id_rs1_i | input | REG_W | First source register of the decode instruction |
| id_rs2_i | input | REG_W | Second source register of the decode instruction |
| id_uses_rs1_i | input | 1 | Decode instruction reads its first source |
| id_uses_rs2_i | input | 1 | Decode instruction reads its second source |
| id_is_branch_i | input | 1 | Decode instruction is a conditional branch |
| br_taken_i | input | 1 | Result of the decode-stage comparator |
| ex_is_load_i | input | 1 | Execute-stage instruction is a load |
| ex_rd_i | input | REG_W | Destination register of the execute-stage instruction |
| mem_access_i | input | 1 | Memory stage reads or writes data memory this cycle |
| pc_we_o | output | 1 | Program counter write enable |
| ifid_we_o | output | 1 | Fetch/decode register write enable |
| bubble_o | output | 1 | Replace the control bits entering decode/execute with no-op values |
| ifid_flush_o | output | 1 | Load a no-op into the fetch/decode register |
| pc_sel_branch_o | output | 1 | Select the branch target as the next program counter |

## Verification
The bench builds three copies of the block. The main copy uses predict-not-taken with split memories. A second copy uses branch-stall mode with a shared memory, and a third uses delay-slot mode. Every copy sees the same stimulus, so one input pattern shows how the three branch policies differ and whether the shared-memory guard is honoured. The main copy also drives a small pipeline model. In that model, whole instruction sequences are timed: a load with a dependent or an independent follower, taken and not-taken branches, a load on register 0, and a load feeding a branch.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    BR_STALL = 2'd0,
    BR_FLUSH = 2'd1,
    BR_DELAY = 2'd2
  } br_mode_e;
endpackage

// File: rtl/hz_load_use.sv
module hz_load_use #(
  parameter int REG_W = 5,
  parameter int NSRC  = 2
) (
  input  logic [NSRC-1:0][REG_W-1:0] src_i,
  input  logic [NSRC-1:0]            src_used_i,
  input  logic                       ex_is_load_i,
  input  logic [REG_W-1:0]           ex_rd_i,
  output logic                       stall_o
);
  logic [NSRC-1:0] hit;
  logic            rd_live;

  assign rd_live = ex_is_load_i && (ex_rd_i != '0);

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    assign hit[s] = src_used_i[s] && (src_i[s] == ex_rd_i);
  end

  assign stall_o = rd_live && (|hit);
endmodule

// File: rtl/hz_branch.sv
module hz_branch
  import hz_pkg::*;
#(
  parameter br_mode_e MODE = BR_FLUSH
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic branch_i,
  input  logic taken_i,
  input  logic hold_i,
  output logic pc_sel_o,
  output logic flush_o
);
  logic live;
  assign live     = branch_i && !hold_i;
  assign pc_sel_o = live && taken_i;

  if (MODE == BR_STALL) begin : g_stall
    assign flush_o = live;
    // R6
    stall_mode_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (branch_i && !hold_i) |-> flush_o);
  end else if (MODE == BR_FLUSH) begin : g_flush
    assign flush_o = pc_sel_o;
    // R5
    flush_only_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flush_o |-> (branch_i && taken_i));
  end else begin : g_delay
    assign flush_o = 1'b0;
    // R7
    delay_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (branch_i && taken_i && !hold_i) |-> (pc_sel_o && !flush_o));
  end
endmodule

// File: rtl/hz_mem_port.sv
module hz_mem_port #(
  parameter bit UNIFIED_MEM = 1'b0
) (
  input  logic mem_access_i,
  output logic stall_o
);
  if (UNIFIED_MEM) begin : g_shared
    assign stall_o = mem_access_i;
  end else begin : g_split
    logic unused_access;
    assign unused_access = mem_access_i;
    assign stall_o       = 1'b0;
  end
endmodule

// File: rtl/hazard_unit.sv
module hazard_unit
  import hz_pkg::*;
#(
  parameter int       REG_W       = 5,
  parameter br_mode_e BR_MODE     = BR_FLUSH,
  parameter bit       UNIFIED_MEM = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REG_W-1:0] id_rs1_i,
  input  logic [REG_W-1:0] id_rs2_i,
  input  logic             id_uses_rs1_i,
  input  logic             id_uses_rs2_i,
  input  logic             id_is_branch_i,
  input  logic             br_taken_i,
  input  logic             ex_is_load_i,
  input  logic [REG_W-1:0] ex_rd_i,
  input  logic             mem_access_i,
  output logic             pc_we_o,
  output logic             ifid_we_o,
  output logic             bubble_o,
  output logic             ifid_flush_o,
  output logic             pc_sel_branch_o
);
  localparam int NSRC = 2;

  logic lu_stall, mem_stall, hold;

  hz_load_use #(.REG_W(REG_W), .NSRC(NSRC)) u_load_use (
    .src_i        ({id_rs2_i, id_rs1_i}),
    .src_used_i   ({id_uses_rs2_i, id_uses_rs1_i}),
    .ex_is_load_i (ex_is_load_i),
    .ex_rd_i      (ex_rd_i),
    .stall_o      (lu_stall)
  );

  hz_mem_port #(.UNIFIED_MEM(UNIFIED_MEM)) u_mem_port (
    .mem_access_i (mem_access_i),
    .stall_o      (mem_stall)
  );

  assign hold = lu_stall || mem_stall;

  hz_branch #(.MODE(BR_MODE)) u_branch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .branch_i (id_is_branch_i),
    .taken_i  (br_taken_i),
    .hold_i   (hold),
    .pc_sel_o (pc_sel_branch_o),
    .flush_o  (ifid_flush_o)
  );

  // hold decode in place; no-op control into execute
  assign pc_we_o   = !hold;
  assign ifid_we_o = !hold;
  assign bubble_o  = hold;

  // R1
  load_use_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_is_load_i && (ex_rd_i != '0) &&
     ((id_uses_rs1_i && id_rs1_i == ex_rd_i) || (id_uses_rs2_i && id_rs2_i == ex_rd_i)))
    |-> (!pc_we_o && !ifid_we_o && bubble_o));

  // R2
  zero_reg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ex_rd_i == '0) && !(UNIFIED_MEM && mem_access_i)) |-> (pc_we_o && !bubble_o));

  // R8
  stall_over_branch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bubble_o |-> (!pc_sel_branch_o && !ifid_flush_o));

  // R4
  taken_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_is_branch_i && br_taken_i && ifid_we_o) |-> pc_sel_branch_o);

  // R9
  shared_mem_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (UNIFIED_MEM && mem_access_i) |-> (!pc_we_o && bubble_o));
endmodule

// File: tb/tb_hazard_unit.sv
`timescale 1ns/1ps
module tb_hazard_unit;
  import hz_pkg::*;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic [4:0] rs1, rs2, ex_rd;
  logic u1, u2, br, tk, ld, mem;
  logic [4:0] o0, o1, o2;

  hazard_unit #(.REG_W(5), .BR_MODE(BR_FLUSH), .UNIFIED_MEM(1'b0)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .id_rs1_i(rs1), .id_rs2_i(rs2),
    .id_uses_rs1_i(u1), .id_uses_rs2_i(u2), .id_is_branch_i(br), .br_taken_i(tk),
    .ex_is_load_i(ld), .ex_rd_i(ex_rd), .mem_access_i(mem),
    .pc_we_o(o0[4]), .ifid_we_o(o0[3]), .bubble_o(o0[2]), .ifid_flush_o(o0[1]),
    .pc_sel_branch_o(o0[0]));

  hazard_unit #(.REG_W(5), .BR_MODE(BR_STALL), .UNIFIED_MEM(1'b1)) dut_stl (
    .clk_i(clk), .rst_ni(rst_ni), .id_rs1_i(rs1), .id_rs2_i(rs2),
    .id_uses_rs1_i(u1), .id_uses_rs2_i(u2), .id_is_branch_i(br), .br_taken_i(tk),
    .ex_is_load_i(ld), .ex_rd_i(ex_rd), .mem_access_i(mem),
    .pc_we_o(o1[4]), .ifid_we_o(o1[3]), .bubble_o(o1[2]), .ifid_flush_o(o1[1]),
    .pc_sel_branch_o(o1[0]));

  hazard_unit #(.REG_W(5), .BR_MODE(BR_DELAY), .UNIFIED_MEM(1'b0)) dut_dly (
    .clk_i(clk), .rst_ni(rst_ni), .id_rs1_i(rs1), .id_rs2_i(rs2),
    .id_uses_rs1_i(u1), .id_uses_rs2_i(u2), .id_is_branch_i(br), .br_taken_i(tk),
    .ex_is_load_i(ld), .ex_rd_i(ex_rd), .mem_access_i(mem),
    .pc_we_o(o2[4]), .ifid_we_o(o2[3]), .bubble_o(o2[2]), .ifid_flush_o(o2[1]),
    .pc_sel_branch_o(o2[0]));

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard: expected output vectors {pc_we,ifid_we,bubble,flush,pc_sel}
  typedef struct {
    string      req;
    logic [4:0] e0, e1, e2;
  } exp_t;
  exp_t sb[$];
  bit vec_phase = 1'b1;

  always @(negedge clk) begin
    if (vec_phase && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check({e.req, " flush-mode"}, int'(o0), int'(e.e0));
      check({e.req, " stall-mode"}, int'(o1), int'(e.e1));
      check({e.req, " delay-mode"}, int'(o2), int'(e.e2));
    end
  end

  task automatic drive_vec(input string req,
                           input logic [4:0] a1, input logic [4:0] a2,
                           input logic v1, input logic v2,
                           input logic b, input logic t,
                           input logic l, input logic [4:0] d, input logic m,
                           input logic [4:0] e0, input logic [4:0] e1, input logic [4:0] e2);
    exp_t e;
    @(posedge clk); #1;
    rs1 = a1; rs2 = a2; u1 = v1; u2 = v2; br = b; tk = t; ld = l; ex_rd = d; mem = m;
    e.req = req; e.e0 = e0; e.e1 = e1; e.e2 = e2;
    sb.push_back(e);
  endtask

  // pipeline model driven by the main instance
  typedef struct packed {
    logic       v, ld, mem, br, tk, u1, u2;
    logic [4:0] rd, rs1, rs2;
    logic [3:0] tgt;
  } ins_t;
  ins_t prog[8];
  int   plen;

  function automatic ins_t mk(input logic l, input logic m, input logic b, input logic t,
                              input logic v1, input logic v2, input logic [4:0] d,
                              input logic [4:0] a1, input logic [4:0] a2, input logic [3:0] g);
    ins_t x;
    x.v = 1'b1; x.ld = l; x.mem = m; x.br = b; x.tk = t; x.u1 = v1; x.u2 = v2;
    x.rd = d; x.rs1 = a1; x.rs2 = a2; x.tgt = g;
    return x;
  endfunction

  task automatic run_prog(input int n_done, output int cycles);
    ins_t ifid, idex, exmem, memwb, nx;
    logic [4:0] o;
    int pc, done;
    ifid = '0; idex = '0; exmem = '0; memwb = '0;
    pc = 0; done = 0; cycles = 0;
    @(posedge clk);
    while (done < n_done && cycles < 100) begin
      #1;
      rs1 = ifid.rs1; rs2 = ifid.rs2;
      u1 = ifid.v && ifid.u1; u2 = ifid.v && ifid.u2;
      br = ifid.v && ifid.br; tk = ifid.tk;
      ld = idex.v && idex.ld; ex_rd = idex.rd;
      mem = exmem.v && exmem.mem;
      @(negedge clk);
      o = o0;
      @(posedge clk);
      cycles++;
      if (memwb.v) done++;
      nx = (pc < plen) ? prog[pc] : '0;
      memwb = exmem;
      exmem = idex;
      if (o[4]) pc = o[0] ? int'(ifid.tgt) : pc + 1;
      idex = o[2] ? '0 : ifid;
      if (o[3]) ifid = o[1] ? '0 : nx;
    end
  endtask

  initial begin
    rs1 = '0; rs2 = '0; u1 = 0; u2 = 0; br = 0; tk = 0; ld = 0; ex_rd = '0; mem = 0;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;

    // R10 idle
    drive_vec("R10 idle", 5'd0, 5'd0, 0, 0, 0, 0, 0, 5'd0, 0, 5'b11000, 5'b11000, 5'b11000);
    // R1 rs1 match
    drive_vec("R1 rs1 hit", 5'd3, 5'd4, 1, 1, 0, 0, 1, 5'd3, 0, 5'b00100, 5'b00100, 5'b00100);
    // R1 rs2 match
    drive_vec("R1 rs2 hit", 5'd6, 5'd7, 0, 1, 0, 0, 1, 5'd7, 0, 5'b00100, 5'b00100, 5'b00100);
    // R2 unused source
    drive_vec("R2 unused src", 5'd6, 5'd7, 1, 0, 0, 0, 1, 5'd7, 0, 5'b11000, 5'b11000, 5'b11000);
    // R2 register zero
    drive_vec("R2 reg zero", 5'd0, 5'd0, 1, 1, 0, 0, 1, 5'd0, 0, 5'b11000, 5'b11000, 5'b11000);
    // R4 R5 R6 R7 taken branch, non-load match in EX
    drive_vec("R4 taken", 5'd2, 5'd9, 1, 1, 1, 1, 0, 5'd2, 0, 5'b11011, 5'b11011, 5'b11001);
    // R5 R6 R7 not taken
    drive_vec("R6 not taken", 5'd2, 5'd9, 1, 1, 1, 0, 0, 5'd0, 0, 5'b11000, 5'b11010, 5'b11000);
    // R8 load-use with taken branch
    drive_vec("R8 priority", 5'd5, 5'd9, 1, 1, 1, 1, 1, 5'd5, 0, 5'b00100, 5'b00100, 5'b00100);
    // R9 memory access only
    drive_vec("R9 mem access", 5'd0, 5'd0, 0, 0, 0, 0, 0, 5'd0, 1, 5'b11000, 5'b00100, 5'b11000);
    // R9 R8 memory access with taken branch
    drive_vec("R9 mem+branch", 5'd1, 5'd1, 1, 1, 1, 1, 0, 5'd8, 1, 5'b11011, 5'b00100, 5'b11001);
    @(posedge clk);
    @(negedge clk);
    vec_phase = 1'b0;

    begin
      int c;
      // R1 load then dependent subtract
      prog[0] = mk(1, 1, 0, 0, 1, 0, 5'd1, 5'd2, 5'd0, 4'd0);
      prog[1] = mk(0, 0, 0, 0, 1, 1, 5'd2, 5'd1, 5'd3, 4'd0);
      plen = 2; run_prog(2, c); check("R1 load-use cycles", c, 7);
      // R3 load then independent
      prog[1] = mk(0, 0, 0, 0, 1, 1, 5'd4, 5'd5, 5'd6, 4'd0);
      plen = 2; run_prog(2, c); check("R3 independent cycles", c, 6);
      // R2 load to register 0 then reader of r0
      prog[0] = mk(1, 1, 0, 0, 1, 0, 5'd0, 5'd2, 5'd0, 4'd0);
      prog[1] = mk(0, 0, 0, 0, 1, 1, 5'd4, 5'd0, 5'd0, 4'd0);
      plen = 2; run_prog(2, c); check("R2 r0 cycles", c, 6);
      // R5 taken branch skips prog[1]
      prog[0] = mk(0, 0, 1, 1, 1, 1, 5'd0, 5'd1, 5'd2, 4'd2);
      prog[1] = mk(0, 0, 0, 0, 1, 1, 5'd7, 5'd3, 5'd4, 4'd0);
      prog[2] = mk(0, 0, 0, 0, 1, 1, 5'd8, 5'd3, 5'd4, 4'd0);
      plen = 3; run_prog(2, c); check("R5 taken cycles", c, 7);
      // R5 not-taken branch
      prog[0] = mk(0, 0, 1, 0, 1, 1, 5'd0, 5'd1, 5'd2, 4'd2);
      plen = 2; run_prog(2, c); check("R5 not-taken cycles", c, 6);
      // R8 load feeding a taken branch
      prog[0] = mk(1, 1, 0, 0, 1, 0, 5'd1, 5'd2, 5'd0, 4'd0);
      prog[1] = mk(0, 0, 1, 1, 1, 1, 5'd0, 5'd1, 5'd2, 4'd3);
      prog[2] = mk(0, 0, 0, 0, 1, 1, 5'd7, 5'd3, 5'd4, 4'd0);
      prog[3] = mk(0, 0, 0, 0, 1, 1, 5'd8, 5'd3, 5'd4, 4'd0);
      plen = 4; run_prog(3, c); check("R8 load+branch cycles", c, 9);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #500000;
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule